// File: doc/BRIEF.md
# Rotating-Key Serial Byte Descrambler

This block recovers plain bytes from a serial stream of scrambled bits. A circular key register holds an 8-bit pattern and rotates one place to the right for every bit it accepts. Before each rotation, its lowest stage supplies the key bit for that step. The block XORs that key bit with the arriving cipher bit and shifts the result into a byte assembler. When eight bits have been accepted, the assembled byte appears on the output together with a one-cycle strobe.

After eight rotations the key register is back in its loaded state, so consecutive characters need no reload and no keystream generator. Taken together, the scheme amounts to a bytewise XOR of the cipher with the loaded key: received bit i of a character is combined with key bit i. A stall (no valid bit in a cycle) freezes both the key register and the assembler, so gaps in the stream do not break alignment.

Top module: `rot_key_descrambler`

## Requirements
- R1: Each accepted bit rotates the key register right by one place: bit 0 moves into bit 7 and every other bit moves down one place.
- R2: The key bit for a step is key bit 0 before that step's rotation. A loaded key of 0xE8 yields key bits 0,0,0,1,0,1,1,1 over eight accepted bits.
- R3: After eight accepted bits with no load in between, the key register again holds the loaded value, so the next character decodes with the same key.
- R4: Each recovered bit is the received cipher bit XOR the current key bit.
- R5: The first recovered bit of a character lands in byte_out[0] and the eighth lands in byte_out[7]. With key 0xE8, the cipher bits 0,1,0,1,0,0,0,1 (cipher byte 0x8A) decode to 0x62.
- R6: The key register and the bit count change only in cycles where bit_valid is 1 (or key_load is 1). Idle cycles between bits do not change the decoded result.
- R7: byte_valid is high for exactly one cycle, the cycle after the clock edge that samples the eighth bit. byte_out changes only together with byte_valid and otherwise holds its last value.
- R8: key_load=1 writes key_value into the key register, clears the bit count and drops any partly assembled byte. If key_load and bit_valid are both 1 in the same cycle, the load wins and the bit is discarded.
- R9: While reset is held, byte_out is 0x00, byte_valid is 0 and the key register and bit count are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_load | input | 1 | Load key_value and restart the bit count |
| key_value | input | 8 | Key pattern to load |
| bit_valid | input | 1 | bit_in carries a cipher bit this cycle |
| bit_in | input | 1 | Serial cipher bit |
| byte_out | output | 8 | Last recovered byte |
| byte_valid | output | 1 | One-cycle strobe for a new byte_out |

## Verification
Two functions can fall in the same cycle: a key load and the acceptance of a cipher bit. The bench provokes this by raising key_load in the same cycle as a valid bit in the middle of a character. It then sends a full byte under the new key and judges the outcome at the byte output. The decoded byte must match the new key with no shift, which shows that the coinciding bit was dropped and the count restarted. A second overlap is a character ending while the next character's first bit is already present; back-to-back bytes show that the strobe and the restored key line up.

// File: rtl/rkd_pkg.sv
package rkd_pkg;
  localparam int unsigned RKD_KEY_W = 8;
  localparam int unsigned RKD_SYNC_STAGES = 2;
endpackage

// File: rtl/rkd_reset_sync.sv
module rkd_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rkd_key_ring.sv
module rkd_key_ring #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         advance,
  output logic         key_bit,
  output logic [W-1:0] ring_q
);
  logic [W-1:0] ring_d;
  logic         ring_en;

  always_comb begin
    ring_en = load | advance;
    ring_d  = ring_q;
    if (load)         ring_d = load_val;
    else if (advance) ring_d = {ring_q[0], ring_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      ring_q <= '0;
    else if (ring_en) ring_q <= ring_d;
  end

  assign key_bit = ring_q[0];
endmodule

// File: rtl/rkd_byte_collector.sv
module rkd_byte_collector #(
  parameter int unsigned W = 8
) (
  input  logic                 clk,
  input  logic                 srst_n,
  input  logic                 restart,
  input  logic                 take,
  input  logic                 plain_bit,
  output logic [W-1:0]         word_q,
  output logic                 word_vld_q,
  output logic [$clog2(W)-1:0] cnt_q
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  shift_q, shift_d;
  logic [CW-1:0] cnt_d;
  logic [W-1:0]  word_d;
  logic          word_vld_d;
  logic          last_bit;

  always_comb begin
    last_bit   = take && !restart && (cnt_q == LAST);
    shift_d    = shift_q;
    cnt_d      = cnt_q;
    word_d     = word_q;
    word_vld_d = 1'b0;
    if (restart) begin
      shift_d = '0;
      cnt_d   = '0;
    end else if (take) begin
      shift_d = {plain_bit, shift_q[W-1:1]};
      cnt_d   = last_bit ? '0 : cnt_q + 1'b1;
      if (last_bit) begin
        word_d     = {plain_bit, shift_q[W-1:1]};
        word_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      shift_q    <= '0;
      cnt_q      <= '0;
      word_q     <= '0;
      word_vld_q <= 1'b0;
    end else begin
      word_vld_q <= word_vld_d;
      if (restart || take) begin
        shift_q <= shift_d;
        cnt_q   <= cnt_d;
      end
      if (last_bit) word_q <= word_d;
    end
  end
endmodule

// File: rtl/rot_key_descrambler.sv
module rot_key_descrambler #(
  parameter int unsigned W = rkd_pkg::RKD_KEY_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_load,
  input  logic [W-1:0] key_value,
  input  logic         bit_valid,
  input  logic         bit_in,
  output logic [W-1:0] byte_out,
  output logic         byte_valid
);
  localparam int unsigned CW = $clog2(W);

  logic          srst_n;
  logic          key_bit;
  logic [W-1:0]  key_q;
  logic [CW-1:0] cnt_q;
  logic          accept;
  logic          plain_bit;

  assign accept    = bit_valid & ~key_load;
  assign plain_bit = bit_in ^ key_bit;

  rkd_reset_sync #(.STAGES(rkd_pkg::RKD_SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  rkd_key_ring #(.W(W)) u_ring (
    .clk(clk), .srst_n(srst_n), .load(key_load), .load_val(key_value),
    .advance(accept), .key_bit(key_bit), .ring_q(key_q)
  );

  rkd_byte_collector #(.W(W)) u_coll (
    .clk(clk), .srst_n(srst_n), .restart(key_load), .take(bit_valid),
    .plain_bit(plain_bit), .word_q(byte_out), .word_vld_q(byte_valid),
    .cnt_q(cnt_q)
  );
endmodule

// File: rtl/rkd_checker.sv
module rkd_checker #(
  parameter int unsigned W = 8
) (
  input logic                 clk,
  input logic                 srst_n,
  input logic                 key_load,
  input logic [W-1:0]         key_value,
  input logic                 bit_valid,
  input logic [W-1:0]         key_q,
  input logic [$clog2(W)-1:0] cnt_q,
  input logic [W-1:0]         byte_out,
  input logic                 byte_valid
);
  logic [W-1:0] shadow_key;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       shadow_key <= '0;
    else if (key_load) shadow_key <= key_value;
  end

  p_rotate_r1: assert property (@(posedge clk) disable iff (!srst_n)
    (bit_valid && !key_load) |=> key_q == {$past(key_q[0]), $past(key_q[W-1:1])});

  p_key_back_r3: assert property (@(posedge clk) disable iff (!srst_n)
    byte_valid |-> key_q == shadow_key);

  p_stall_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (!bit_valid && !key_load) |=> ($stable(key_q) && $stable(cnt_q)));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!srst_n)
    byte_valid |=> !byte_valid);

  p_hold_out_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !byte_valid |-> $stable(byte_out));

  p_load_r8: assert property (@(posedge clk) disable iff (!srst_n)
    key_load |=> (key_q == $past(key_value) && cnt_q == '0));
endmodule

bind rot_key_descrambler rkd_checker #(.W(W)) u_chk (
  .clk(clk), .srst_n(srst_n), .key_load(key_load), .key_value(key_value),
  .bit_valid(bit_valid), .key_q(key_q), .cnt_q(cnt_q),
  .byte_out(byte_out), .byte_valid(byte_valid)
);

// File: tb/rot_key_descrambler_bench.sv
module rot_key_descrambler_bench;
  logic       clk;
  logic       rst_n;
  logic       key_load;
  logic [7:0] key_value;
  logic       bit_valid;
  logic       bit_in;
  logic [7:0] byte_out;
  logic       byte_valid;

  int total = 0;
  int bad   = 0;
  logic [7:0] got_q[$];
  bit done  = 0;

  rot_key_descrambler u_rot_key_descrambler (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_value(key_value),
    .bit_valid(bit_valid), .bit_in(bit_in), .byte_out(byte_out),
    .byte_valid(byte_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (byte_valid) got_q.push_back(byte_out);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_key(input logic [7:0] k, input logic with_bit, input logic b);
    @(negedge clk);
    key_load = 1'b1; key_value = k; bit_valid = with_bit; bit_in = b;
    @(negedge clk);
    key_load = 1'b0; bit_valid = 1'b0;
  endtask

  // drives the eight bits of cipher, bit 0 first; gap idle cycles between bits
  task automatic send_byte(input logic [7:0] c, input int gap);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bit_valid = 1'b1; bit_in = c[i];
      if (gap > 0 && i < 7) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          bit_valid = 1'b0; bit_in = ~c[i];
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R9 byte_out", byte_out, 8'h00);
    check("R9 byte_valid", byte_valid, 0);
    check("R9 no strobe", got_q.size(), 0);
  endtask

  task automatic t_example;
    got_q.delete();
    load_key(8'hE8, 1'b0, 1'b0);
    send_byte(8'h8A, 0);
    @(negedge clk); bit_valid = 1'b0;
    // strobe registered at edge sampling bit 8, seen at this negedge
    check("R7 strobe timing", byte_valid, 1);
    check("R5 R2 R4 example byte", byte_out, 8'h62);
    @(negedge clk);
    check("R7 one cycle", byte_valid, 0);
    check("R7 hold", byte_out, 8'h62);
    idle(5);
    check("R7 hold idle", byte_out, 8'h62);
    check("R7 single pulse", got_q.size(), 1);
  endtask

  task automatic t_back_to_back;
    logic [7:0] p [3] = '{8'h41, 8'hC3, 8'h00};
    got_q.delete();
    load_key(8'h5B, 1'b0, 1'b0);
    for (int n = 0; n < 3; n++) send_byte(p[n] ^ 8'h5B, 0);
    idle(3);
    check("R3 count", got_q.size(), 3);
    for (int n = 0; n < 3; n++)
      if (n < got_q.size()) check("R3 R1 back-to-back", got_q[n], p[n]);
  endtask

  task automatic t_rotation_visible;
    got_q.delete();
    load_key(8'h01, 1'b0, 1'b0);
    send_byte(8'h00, 0);
    idle(3);
    check("R1 key bit order", got_q.size() > 0 ? got_q[0] : 8'hXX, 8'h01);
    got_q.delete();
    load_key(8'h80, 1'b0, 1'b0);
    send_byte(8'hFF, 0);
    idle(3);
    check("R1 R4 key 80 inverted", got_q.size() > 0 ? got_q[0] : 8'hXX, 8'h7F);
  endtask

  task automatic t_stalls;
    got_q.delete();
    load_key(8'hA7, 1'b0, 1'b0);
    send_byte(8'h39 ^ 8'hA7, 3);
    send_byte(8'hD2 ^ 8'hA7, 1);
    idle(3);
    check("R6 stall count", got_q.size(), 2);
    if (got_q.size() == 2) begin
      check("R6 stalled byte 1", got_q[0], 8'h39);
      check("R6 stalled byte 2", got_q[1], 8'hD2);
    end
  endtask

  task automatic t_load_collide;
    got_q.delete();
    load_key(8'h11, 1'b0, 1'b0);
    send_byte(8'h00, 0);       // full byte then three partial bits
    @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk); bit_in = 1'b0;
    @(negedge clk); bit_in = 1'b1;
    load_key(8'h6C, 1'b1, 1'b1); // bit coincides with load, dropped
    send_byte(8'hF0 ^ 8'h6C, 0);
    idle(3);
    check("R8 strobes", got_q.size(), 2);
    if (got_q.size() == 2) begin
      check("R8 pre-load byte", got_q[0], 8'h11);
      check("R8 new key clean start", got_q[1], 8'hF0);
    end
  endtask

  initial begin
    rst_n = 1'b0; key_load = 1'b0; key_value = '0; bit_valid = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_example();
    t_back_to_back();
    t_rotation_visible();
    t_stalls();
    t_load_collide();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule